// File: doc/BRIEF.md
# Fetch Stream Redirect Controller

This block steers the fetch address of an in-order core and keeps track of the sequence numbers attached to every fetched line. It holds two independent counters. The stream number marks the instruction stream chosen by execute. The prediction number marks the last predicted-taken branch that the predictor stage followed. Each line the fetch-address generator issues carries both numbers and a unique line number.

Execute reports each branch outcome as a 3-bit reason code. It also reports the branch target and the sequential address after the branch. The predictor stage reports predicted-taken targets, tagged with the stream number they were predicted under. The block arbitrates between the two sources, updates the counters, moves the fetch address and halts or resumes issue.

At the input of the line-to-instruction splitter, the block decides for each arriving line whether it is kept or dropped. After a prediction, sequential lines that were fetched under the old prediction number are dropped. Lines from a newer execute-driven stream always get through.

Top module: `fetch_redirect_ctrl`

## Requirements
- R1: A line is issued in a cycle where `issue_ready` is high and fetch is not halted. It carries the current stream number, prediction number, fetch address and line number. The line number rises by exactly one per issued line and holds when no line is issued. After reset the fetch address is `RESET_PC` and the stream, prediction and line numbers are 0.
- R2: When no redirect is taken, each issued line moves the fetch address on by `LINE_BYTES`.
- R3: An execute outcome with reason 2 (taken but not predicted), 4 (wrong target) or 6 (interrupt) adds one to the stream number and loads `ex_target` as the next fetch address.
- R4: An execute outcome with reason 3 (predicted taken but not taken) adds one to the stream number and loads `ex_next_pc`, the sequential address after the branch.
- R5: Execute reasons 0 (no branch) and 1 (correctly predicted) leave the stream number and the fetch address untouched.
- R6: Execute reason 5 (suspend) adds one to the stream number and loads `ex_next_pc` as the wakeup address. It then stops line issue until `wake` is seen or a later execute redirect arrives.
- R7: A predictor redirect takes effect only when `pr_stream` equals the current stream number. It then adds one to the prediction number, loads `pr_target` and raises `split_flush` in that same cycle. A redirect with a stale stream number changes nothing.
- R8: When an execute redirect (reasons 2 to 6) and a predictor redirect occur in the same cycle, only the execute redirect is applied and the prediction number holds.
- R9: From the cycle after a prediction is applied, a splitter line is rejected (`split_accept` low) if its stream number equals the stream of that prediction and its prediction number differs from the new one.
- R10: A splitter line whose stream number differs from the blocked stream, or whose prediction number equals the new one, is accepted.
- R11: Sequence counters are `SEQ_W` bits (8 by default), compare by equality only, and wrap from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_ready | input | 1 | Fetch may issue a line this cycle |
| wake | input | 1 | Resume issue after a suspend |
| ex_valid | input | 1 | Execute branch outcome valid |
| ex_reason | input | 3 | Execute outcome reason code (0..6) |
| ex_target | input | AW | Branch or interrupt target address |
| ex_next_pc | input | AW | Sequential address after the branch or hint |
| pr_valid | input | 1 | Predictor redirect valid |
| pr_stream | input | SEQ_W | Stream number the prediction was made under |
| pr_target | input | AW | Predicted target address |
| line_valid | output | 1 | A line is issued this cycle |
| line_addr | output | AW | Fetch address of the issued line |
| line_stream | output | SEQ_W | Stream number tag |
| line_pred | output | SEQ_W | Prediction number tag |
| line_num | output | SEQ_W | Line number tag |
| fetch_halted | output | 1 | Issue stopped by a suspend |
| split_flush | output | 1 | Splitter must drop its buffered lines |
| split_in_valid | input | 1 | A line arrives at the splitter |
| split_in_stream | input | SEQ_W | Stream tag of the arriving line |
| split_in_pred | input | SEQ_W | Prediction tag of the arriving line |
| split_accept | output | 1 | Arriving line is kept |

## Verification
The counters, the fetch address and the halt flag all drive the tags of the next issued line. A wrong stream or prediction count therefore shows on `line_stream` or `line_pred` in the first issue cycle after the faulty update. A wrong redirect address shows on `line_addr` in that same cycle. A wrong blocking state in the splitter filter appears on `split_accept` for the first stale or new-stream line presented after the prediction. The bench offers such lines on the cycle right after each update, so each fault is seen within one cycle.

// File: rtl/frc_pkg.sv
// Package: shared reason codes and helpers for the fetch redirect controller.
// Assumes a 3-bit reason field coming from execute.
package frc_pkg;

    typedef enum logic [2:0] {
        RSN_NONE      = 3'd0,
        RSN_CORRECT   = 3'd1,
        RSN_UNPRED    = 3'd2,
        RSN_BAD_DIR   = 3'd3,
        RSN_BAD_TGT   = 3'd4,
        RSN_SUSPEND   = 3'd5,
        RSN_INTERRUPT = 3'd6
    } redirect_rsn_e;

    // True when an execute reason moves fetch to a new stream.
    function automatic logic rsn_changes_stream(input logic [2:0] rsn);
        return (rsn >= 3'd2) && (rsn <= 3'd6);
    endfunction

    // True when the new fetch address is the sequential one after the branch.
    function automatic logic rsn_uses_next_pc(input logic [2:0] rsn);
        return (rsn == 3'(RSN_BAD_DIR)) || (rsn == 3'(RSN_SUSPEND));
    endfunction

endpackage

// File: rtl/frc_seq_track.sv
// Module: frc_seq_track
// Holds the stream and prediction counters and arbitrates between execute
// and predictor redirects. An execute redirect always wins. A predictor
// redirect is honoured only when its stream tag equals the current stream.
// Assumes: counters wrap and are compared for equality only.
module frc_seq_track #(
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_valid,
    input  logic [2:0]       ex_reason,
    input  logic             pr_valid,
    input  logic [SEQ_W-1:0] pr_stream,
    output logic [SEQ_W-1:0] stream_q,
    output logic [SEQ_W-1:0] pred_q,
    output logic             ex_redirect,
    output logic             pr_apply
);
    import frc_pkg::*;

    localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

    // Decode which redirect source takes effect this cycle.
    always_comb begin
        ex_redirect = ex_valid && rsn_changes_stream(ex_reason);
        pr_apply    = pr_valid && !ex_redirect && (pr_stream == stream_q);
    end

    // Advance the sequence counters on an accepted redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stream_q <= '0;
            pred_q   <= '0;
        end else begin
            if (ex_redirect) stream_q <= stream_q + SEQ_ONE;
            if (pr_apply)    pred_q   <= pred_q + SEQ_ONE;
        end
    end

    AST_EX_BUMPS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_reason >= 3'd2 && ex_reason <= 3'd6) |=> (stream_q == $past(stream_q) + SEQ_ONE)); // R3
    AST_QUIET_REASON_KEEPS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_reason <= 3'd1) |=> $stable(stream_q)); // R5
    AST_EX_BEATS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_reason >= 3'd2 && ex_reason <= 3'd6 && pr_valid) |=> $stable(pred_q)); // R8
    AST_STALE_PRED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_valid && pr_stream != stream_q) |=> $stable(pred_q)); // R7

endmodule

// File: rtl/frc_fetch_gen.sv
// Module: frc_fetch_gen
// Fetch-address generator: issues one line per ready cycle unless halted,
// numbers every issued line, and loads a new address on a redirect.
// Assumes: at most one redirect source is active (arbitrated upstream).
module frc_fetch_gen #(
    parameter int              AW         = 32,
    parameter int              SEQ_W      = 8,
    parameter int              LINE_BYTES = 16,
    parameter logic [AW-1:0]   RESET_PC   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_ready,
    input  logic             wake,
    input  logic             ex_redirect,
    input  logic [2:0]       ex_reason,
    input  logic [AW-1:0]    ex_target,
    input  logic [AW-1:0]    ex_next_pc,
    input  logic             pr_apply,
    input  logic [AW-1:0]    pr_target,
    output logic             line_valid,
    output logic [AW-1:0]    fetch_pc,
    output logic [SEQ_W-1:0] line_num,
    output logic             halted
);
    import frc_pkg::*;

    localparam logic [AW-1:0]    PC_STEP = AW'(LINE_BYTES);
    localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

    logic [AW-1:0] redirect_pc;

    // Issue whenever the consumer is ready and fetch is running.
    always_comb line_valid = issue_ready && !halted;

    // Pick the address a redirect loads.
    always_comb begin
        if (ex_redirect)
            redirect_pc = rsn_uses_next_pc(ex_reason) ? ex_next_pc : ex_target;
        else
            redirect_pc = pr_target;
    end

    // Update fetch address, line counter and halt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc <= RESET_PC;
            line_num <= '0;
            halted   <= 1'b0;
        end else begin
            if (line_valid) line_num <= line_num + SEQ_ONE;
            if (ex_redirect || pr_apply) fetch_pc <= redirect_pc;
            else if (line_valid)         fetch_pc <= fetch_pc + PC_STEP;
            if (ex_redirect)  halted <= (ex_reason == 3'(RSN_SUSPEND));
            else if (wake)    halted <= 1'b0;
        end
    end

    AST_LINE_NUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ready && !halted) |=> (line_num == $past(line_num) + SEQ_ONE)); // R1
    AST_LINE_NUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_ready && !halted) |=> $stable(line_num)); // R1
    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !ex_redirect && !pr_apply) |=> (fetch_pc == $past(fetch_pc) + PC_STEP)); // R2
    AST_HALT_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !line_valid); // R6
    AST_SUSPEND_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_redirect && ex_reason == 3'd5) |=> (halted && fetch_pc == $past(ex_next_pc))); // R6

endmodule

// File: rtl/frc_line_filter.sv
// Module: frc_line_filter
// Splitter-side filter: after a prediction, remembers the predicted stream
// and the new prediction number, and rejects lines of that stream that
// carry any other prediction number. Other streams pass untouched.
// Assumes: pr_apply is a single-cycle pulse with stream_q/pred_q pre-update.
module frc_line_filter #(
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pr_apply,
    input  logic [SEQ_W-1:0] stream_q,
    input  logic [SEQ_W-1:0] pred_q,
    input  logic             in_valid,
    input  logic [SEQ_W-1:0] in_stream,
    input  logic [SEQ_W-1:0] in_pred,
    output logic             flush,
    output logic             accept
);
    localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

    logic             blk_valid;
    logic [SEQ_W-1:0] blk_stream;
    logic [SEQ_W-1:0] blk_pred;
    logic             stale;

    // Classify the arriving line against the recorded prediction.
    always_comb begin
        stale  = blk_valid && (in_stream == blk_stream) && (in_pred != blk_pred);
        accept = in_valid && !stale;
        flush  = pr_apply;
    end

    // Record the stream and new prediction number of the latest prediction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_valid  <= 1'b0;
            blk_stream <= '0;
            blk_pred   <= '0;
        end else if (pr_apply) begin
            blk_valid  <= 1'b1;
            blk_stream <= stream_q;
            blk_pred   <= pred_q + SEQ_ONE;
        end
    end

    AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pr_apply) && in_valid && in_stream == $past(stream_q) && in_pred != $past(pred_q) + SEQ_ONE) |-> !accept); // R9
    AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> in_valid); // R10

endmodule

// File: rtl/fetch_redirect_ctrl.sv
// Module: fetch_redirect_ctrl (top)
// Ties together the sequence tracker, the fetch-address generator and the
// splitter line filter. Issued lines are tagged with the counters as they
// stand before this cycle's update.
// Assumes: synchronous active-low reset; one redirect of each kind per cycle.
module fetch_redirect_ctrl #(
    parameter int            AW         = 32,
    parameter int            SEQ_W      = 8,
    parameter int            LINE_BYTES = 16,
    parameter logic [AW-1:0] RESET_PC   = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_ready,
    input  logic             wake,
    input  logic             ex_valid,
    input  logic [2:0]       ex_reason,
    input  logic [AW-1:0]    ex_target,
    input  logic [AW-1:0]    ex_next_pc,
    input  logic             pr_valid,
    input  logic [SEQ_W-1:0] pr_stream,
    input  logic [AW-1:0]    pr_target,
    output logic             line_valid,
    output logic [AW-1:0]    line_addr,
    output logic [SEQ_W-1:0] line_stream,
    output logic [SEQ_W-1:0] line_pred,
    output logic [SEQ_W-1:0] line_num,
    output logic             fetch_halted,
    output logic             split_flush,
    input  logic             split_in_valid,
    input  logic [SEQ_W-1:0] split_in_stream,
    input  logic [SEQ_W-1:0] split_in_pred,
    output logic             split_accept
);
    logic [SEQ_W-1:0] stream_q;
    logic [SEQ_W-1:0] pred_q;
    logic             ex_redirect;
    logic             pr_apply;

    frc_seq_track #(.SEQ_W(SEQ_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .ex_reason(ex_reason),
        .pr_valid(pr_valid), .pr_stream(pr_stream),
        .stream_q(stream_q), .pred_q(pred_q),
        .ex_redirect(ex_redirect), .pr_apply(pr_apply)
    );

    frc_fetch_gen #(.AW(AW), .SEQ_W(SEQ_W), .LINE_BYTES(LINE_BYTES), .RESET_PC(RESET_PC)) u_gen (
        .clk(clk), .rst_n(rst_n),
        .issue_ready(issue_ready), .wake(wake),
        .ex_redirect(ex_redirect), .ex_reason(ex_reason),
        .ex_target(ex_target), .ex_next_pc(ex_next_pc),
        .pr_apply(pr_apply), .pr_target(pr_target),
        .line_valid(line_valid), .fetch_pc(line_addr),
        .line_num(line_num), .halted(fetch_halted)
    );

    frc_line_filter #(.SEQ_W(SEQ_W)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .pr_apply(pr_apply), .stream_q(stream_q), .pred_q(pred_q),
        .in_valid(split_in_valid), .in_stream(split_in_stream), .in_pred(split_in_pred),
        .flush(split_flush), .accept(split_accept)
    );

    // Line tags come straight from the tracker.
    always_comb begin
        line_stream = stream_q;
        line_pred   = pred_q;
    end

    AST_PRED_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        split_flush |=> (line_pred == $past(line_pred) + SEQ_W'(1) && line_addr == $past(pr_target))); // R7
    AST_BAD_DIR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_reason == 3'd3) |=> (line_addr == $past(ex_next_pc))); // R4

endmodule

// File: tb/fetch_redirect_ctrl_tb.sv
module fetch_redirect_ctrl_tb;

    localparam int AW = 32;
    localparam int SW = 8;

    typedef struct packed {
        logic        issue;
        logic        wk;
        logic        exv;
        logic [2:0]  rsn;
        logic [31:0] tgt;
        logic [31:0] nxt;
        logic        prv;
        logic [7:0]  prs;
        logic [31:0] prt;
        logic        inv;
        logic [7:0]  ins;
        logic [7:0]  inp;
        logic        e_valid;
        logic [31:0] e_addr;
        logic [7:0]  e_s;
        logic [7:0]  e_p;
        logic [7:0]  e_ln;
        logic        e_flush;
        logic        e_acc;
    } vec_t;

    // Expected values are the state before the vector's clock edge.
    localparam vec_t VECS [14] = '{
        '{1'b1,1'b0,1'b0,3'd0,32'h0,32'h0,1'b0,8'd0,32'h0,1'b0,8'd0,8'd0, 1'b1,32'h1000,8'd0,8'd0,8'd0,1'b0,1'b0},
        '{1'b1,1'b0,1'b1,3'd1,32'h8888,32'h9999,1'b0,8'd0,32'h0,1'b0,8'd0,8'd0, 1'b1,32'h1010,8'd0,8'd0,8'd1,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,3'd0,32'h0,32'h0,1'b1,8'd0,32'h2000,1'b0,8'd0,8'd0, 1'b1,32'h1020,8'd0,8'd0,8'd2,1'b1,1'b0},
        '{1'b1,1'b0,1'b0,3'd0,32'h0,32'h0,1'b0,8'd0,32'h0,1'b1,8'd0,8'd0, 1'b1,32'h2000,8'd0,8'd1,8'd3,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,3'd2,32'h3000,32'h0,1'b1,8'd0,32'h4000,1'b1,8'd0,8'd1, 1'b0,32'h2010,8'd0,8'd1,8'd4,1'b0,1'b1},
        '{1'b1,1'b0,1'b0,3'd0,32'h0,32'h0,1'b1,8'd0,32'h5000,1'b1,8'd1,8'd0, 1'b1,32'h3000,8'd1,8'd1,8'd4,1'b0,1'b1},
        '{1'b1,1'b0,1'b1,3'd3,32'h9000,32'h3104,1'b0,8'd0,32'h0,1'b0,8'd0,8'd0, 1'b1,32'h3010,8'd1,8'd1,8'd5,1'b0,1'b0},
        '{1'b1,1'b0,1'b1,3'd4,32'h6000,32'h0,1'b0,8'd0,32'h0,1'b0,8'd0,8'd0, 1'b1,32'h3104,8'd2,8'd1,8'd6,1'b0,1'b0},
        '{1'b1,1'b0,1'b1,3'd6,32'h7000,32'h0,1'b0,8'd0,32'h0,1'b0,8'd0,8'd0, 1'b1,32'h6000,8'd3,8'd1,8'd7,1'b0,1'b0},
        '{1'b1,1'b0,1'b1,3'd5,32'hAAAA,32'h7204,1'b0,8'd0,32'h0,1'b0,8'd0,8'd0, 1'b1,32'h7000,8'd4,8'd1,8'd8,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,3'd0,32'h0,32'h0,1'b0,8'd0,32'h0,1'b0,8'd0,8'd0, 1'b0,32'h7204,8'd5,8'd1,8'd9,1'b0,1'b0},
        '{1'b1,1'b1,1'b0,3'd0,32'h0,32'h0,1'b0,8'd0,32'h0,1'b0,8'd0,8'd0, 1'b0,32'h7204,8'd5,8'd1,8'd9,1'b0,1'b0},
        '{1'b1,1'b0,1'b0,3'd0,32'h0,32'h0,1'b0,8'd0,32'h0,1'b0,8'd0,8'd0, 1'b1,32'h7204,8'd5,8'd1,8'd9,1'b0,1'b0},
        '{1'b0,1'b0,1'b0,3'd0,32'h0,32'h0,1'b0,8'd0,32'h0,1'b1,8'd0,8'd0, 1'b0,32'h7214,8'd5,8'd1,8'd10,1'b0,1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_ready = 1'b0, wake = 1'b0;
    logic          ex_valid = 1'b0;
    logic [2:0]    ex_reason = '0;
    logic [AW-1:0] ex_target = '0, ex_next_pc = '0;
    logic          pr_valid = 1'b0;
    logic [SW-1:0] pr_stream = '0;
    logic [AW-1:0] pr_target = '0;
    logic          split_in_valid = 1'b0;
    logic [SW-1:0] split_in_stream = '0, split_in_pred = '0;
    logic          line_valid, fetch_halted, split_flush, split_accept;
    logic [AW-1:0] line_addr;
    logic [SW-1:0] line_stream, line_pred, line_num;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fetch_redirect_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .issue_ready(issue_ready), .wake(wake),
        .ex_valid(ex_valid), .ex_reason(ex_reason), .ex_target(ex_target), .ex_next_pc(ex_next_pc),
        .pr_valid(pr_valid), .pr_stream(pr_stream), .pr_target(pr_target),
        .line_valid(line_valid), .line_addr(line_addr), .line_stream(line_stream),
        .line_pred(line_pred), .line_num(line_num), .fetch_halted(fetch_halted),
        .split_flush(split_flush), .split_in_valid(split_in_valid),
        .split_in_stream(split_in_stream), .split_in_pred(split_in_pred),
        .split_accept(split_accept)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        issue_ready = 1'b0; wake = 1'b0; ex_valid = 1'b0; ex_reason = '0;
        ex_target = '0; ex_next_pc = '0; pr_valid = 1'b0; pr_stream = '0;
        pr_target = '0; split_in_valid = 1'b0; split_in_stream = '0; split_in_pred = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle_inputs(); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        #1;
        // R1 / R11: reset state
        check("R11 reset addr", line_addr, 32'h1000);
        check("R11 reset stream", 32'(line_stream), 0);
        check("R11 reset pred", 32'(line_pred), 0);
        check("R1 reset line num", 32'(line_num), 0);
        check("R6 reset not halted", 32'(fetch_halted), 0);

        // Vector walk: R1..R10
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            issue_ready = VECS[i].issue; wake = VECS[i].wk;
            ex_valid = VECS[i].exv; ex_reason = VECS[i].rsn;
            ex_target = VECS[i].tgt; ex_next_pc = VECS[i].nxt;
            pr_valid = VECS[i].prv; pr_stream = VECS[i].prs; pr_target = VECS[i].prt;
            split_in_valid = VECS[i].inv; split_in_stream = VECS[i].ins; split_in_pred = VECS[i].inp;
            #1;
            check($sformatf("R1/R6 valid v%0d", i), 32'(line_valid), 32'(VECS[i].e_valid));
            check($sformatf("R2/R3/R4 addr v%0d", i), line_addr, VECS[i].e_addr);
            check($sformatf("R3/R8 stream v%0d", i), 32'(line_stream), 32'(VECS[i].e_s));
            check($sformatf("R7/R8 pred v%0d", i), 32'(line_pred), 32'(VECS[i].e_p));
            check($sformatf("R1 line num v%0d", i), 32'(line_num), 32'(VECS[i].e_ln));
            check($sformatf("R7 flush v%0d", i), 32'(split_flush), 32'(VECS[i].e_flush));
            check($sformatf("R9/R10 accept v%0d", i), 32'(split_accept), 32'(VECS[i].e_acc));
        end

        // R5: reason 0 with no issue leaves address and stream alone
        @(negedge clk); idle_inputs(); ex_valid = 1'b1; ex_reason = 3'd0; ex_target = 32'hBEEF;
        @(negedge clk); idle_inputs(); #1;
        check("R5 reason0 addr", line_addr, 32'h7214);
        check("R5 reason0 stream", 32'(line_stream), 5);

        // R6: a later execute redirect clears the halt
        @(negedge clk); ex_valid = 1'b1; ex_reason = 3'd5; ex_next_pc = 32'h8000;
        @(negedge clk); idle_inputs(); issue_ready = 1'b1; #1;
        check("R6 halted", 32'(line_valid), 0);
        ex_valid = 1'b1; ex_reason = 3'd2; ex_target = 32'h8800;
        @(negedge clk); idle_inputs(); issue_ready = 1'b1; #1;
        check("R6 resume by redirect", 32'(line_valid), 1);
        check("R6 resume addr", line_addr, 32'h8800);
        check("R3 stream after two", 32'(line_stream), 7);

        // R9: same stream as blocked? blocked is stream 0; matching pred passes
        split_in_valid = 1'b1; split_in_stream = 8'd0; split_in_pred = 8'd1; #1;
        check("R10 matching pred accepted", 32'(split_accept), 1);
        split_in_pred = 8'd2; #1;
        check("R9 other pred rejected", 32'(split_accept), 0);

        // R9: new prediction on current stream re-targets the block
        @(negedge clk); idle_inputs(); pr_valid = 1'b1; pr_stream = 8'd7; pr_target = 32'hC000;
        @(negedge clk); idle_inputs(); split_in_valid = 1'b1; split_in_stream = 8'd7; split_in_pred = 8'd1; #1;
        check("R9 pre-prediction line dropped", 32'(split_accept), 0);
        check("R7 pred tag", 32'(line_pred), 2);
        check("R7 target", line_addr, 32'hC000);
        split_in_stream = 8'd0; #1;
        check("R10 old blocked stream now passes", 32'(split_accept), 1);

        // R11: stream counter wraps after 256 redirects
        do_reset();
        for (int k = 0; k < 256; k++) begin
            @(negedge clk); ex_valid = 1'b1; ex_reason = 3'd6; ex_target = 32'h40;
        end
        @(negedge clk); idle_inputs(); #1;
        check("R11 stream wrap", 32'(line_stream), 0);
        check("R11 wrap addr", line_addr, 32'h40);

        // R1: reset mid-run returns defaults
        do_reset(); #1;
        check("R1 re-reset line num", 32'(line_num), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule